// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

This block moves data between buffers in a flat memory. Two descriptor rings live in that memory. The source ring lists the buffers that hold data. The destination ring lists the empty buffers that receive it. Software owns the write index of each ring and the engine owns the read index. Software writes descriptors into memory and then bumps a write index through a small register port. The engine consumes every entry that lies between its read index and that write index. It copies the data word by word and writes the byte count into the destination descriptor. It then advances both read indices and flags a copy-complete interrupt.

Each descriptor takes 8 bytes. The word at offset 0 holds the buffer byte address. The word at offset 4 holds the byte count in bits 15:0 and the flags in bits 31:16. Flag bit 0 (word bit 16) chains the buffer to the next source descriptor, so several source buffers fill one destination buffer. Flag bit 1 (word bit 17) byte-reverses each copied data word. The memory port accepts one request per cycle. Read data is valid in the cycle after a read request.

The controller has these states. ST_IDLE waits for work or a halt. ST_DST_RD reads the destination buffer address. ST_DST_CHK checks its alignment. ST_SRC_RD0 waits for and reads source word 0. ST_SRC_RD1 reads source word 1. ST_SRC_CHK checks the count. ST_CP_RD and ST_CP_WR alternate to read and write one word. ST_WB writes the count back. ST_HALT holds the engine stopped.

The transitions are as follows:
- ST_IDLE goes to ST_HALT when a halt is requested or an error is pending.
- ST_IDLE goes to ST_DST_RD when both rings hold work.
- ST_DST_CHK goes to ST_HALT on an address error, and otherwise to ST_SRC_RD0.
- ST_SRC_CHK goes to ST_HALT on a length error, and otherwise to ST_CP_RD.
- After the last word of a descriptor, ST_CP_WR returns to ST_SRC_RD0 when the descriptor chains, and otherwise goes to ST_WB.
- ST_WB returns to ST_IDLE.
- ST_HALT returns to ST_IDLE once the halt request and the stopping errors are both clear.

Top module: `ce_copy_engine`

## Requirements
- R1: After reset, every readable register reads 0 and irq is low.
- R2: The control register at 0x10 keeps only bits 18:0. The command register at 0x18 has a writable halt request in bit 0 and a read-only stopped status in bit 3; the other bits read 0.
- R3: Ring registers sit at these offsets: source base 0x00, source entries 0x04, destination base 0x08, destination entries 0x0C, source write index 0x3C, destination write index 0x40, source read index 0x44, destination read index 0x48. The entry count is a power of two. A read index steps to (idx+1) AND (entries-1), and it moves only while it differs from the write index. Writing an entry count clears both indices of that ring.
- R4: The descriptor for index i sits at base+8*i. Its word 0 is the buffer address and its word 1 holds the count in bits 15:0 and the flags in bits 31:16. The engine copies count/4 words to consecutive destination addresses.
- R5: Before the destination read index advances, at the latest on the same edge, the engine writes word 1 of the destination descriptor. Bits 15:0 hold the total bytes copied and bits 31:16 are 0.
- R6: A source descriptor whose flag bit 0 is set chains to the next source descriptor. All chained buffers land back to back in one destination buffer, the destination read index advances once, and the source read index advances once per descriptor.
- R7: A copied word is byte-reversed when its descriptor has flag bit 1 set or when control bit 16 is set. Control bit 17 byte-reverses the written-back count word.
- R8: When command bit 0 is set, the engine stops at the next transfer boundary and then reads 1 in command bit 3. While stopped it makes no memory access and leaves both read indices unchanged. It resumes when bit 0 is cleared.
- R9: Interrupt status bit 0 at 0x30 is set when a transfer completes and is cleared by writing 1 to it. irq equals that bit ANDed with enable bit 0 at 0x2C.
- R10: A source count of zero, or one that is not a multiple of 4, sets error bit 8 at 0x38. The engine then stops without consuming that descriptor.
- R11: If the running total of a transfer would exceed control bits 15:0, error bit 7 is set and the engine stops before copying that descriptor.
- R12: A destination buffer address that is not a multiple of 4 sets error bit 9 and stops the engine before any copy.
- R13: A write-index write that would move the index backwards past pending entries is ignored. It sets error bit 5 for the source ring or bit 6 for the destination ring, and these two bits do not stop the engine. Error bits are cleared by writing 1, and the engine restarts once bits 9:7 are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read |
| irq | output | 1 | Copy-complete interrupt |

## Verification
A wrong read index or a wrong ring mask shows up in the cycle after the write-back. Either the index readback at 0x44 or 0x48 is off, or the next transfer fetches a stale descriptor and copies the wrong pattern. A wrong word counter or pointer corrupts the destination buffer, or the count written back, and the bench compares both word by word as soon as the destination index moves. A wrong halt or error state shows at once: either memory traffic continues or the indices keep moving while command bit 3 reads 1. The other failure is an engine that never resumes, which the bounded polling reports as a timeout.

// File: rtl/ce_pkg.sv
package ce_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DST_RD,
        ST_DST_CHK,
        ST_SRC_RD0,
        ST_SRC_RD1,
        ST_SRC_CHK,
        ST_CP_RD,
        ST_CP_WR,
        ST_WB,
        ST_HALT
    } ce_state_e;

    localparam logic [7:0] OFS_SRC_BASE = 8'h00;
    localparam logic [7:0] OFS_SRC_SIZE = 8'h04;
    localparam logic [7:0] OFS_DST_BASE = 8'h08;
    localparam logic [7:0] OFS_DST_SIZE = 8'h0C;
    localparam logic [7:0] OFS_CTRL     = 8'h10;
    localparam logic [7:0] OFS_CMD      = 8'h18;
    localparam logic [7:0] OFS_IEN      = 8'h2C;
    localparam logic [7:0] OFS_ISTAT    = 8'h30;
    localparam logic [7:0] OFS_ERR      = 8'h38;
    localparam logic [7:0] OFS_SRC_WR   = 8'h3C;
    localparam logic [7:0] OFS_DST_WR   = 8'h40;
    localparam logic [7:0] OFS_SRC_RD   = 8'h44;
    localparam logic [7:0] OFS_DST_RD   = 8'h48;

    localparam int CTRL_W = 19;

    function automatic logic [31:0] byte_rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/ce_ring.sv
module ce_ring #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             size_we,
    input  logic [IDX_W:0]   size_wdata,
    input  logic             wr_we,
    input  logic [IDX_W-1:0] wr_wdata,
    input  logic             adv,
    output logic [IDX_W:0]   size_o,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic             pending,
    output logic             ovf
);
    localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

    logic [IDX_W:0]   size_q;
    logic [IDX_W-1:0] wr_q, rd_q, mask;
    logic [IDX_W-1:0] new_dist, old_dist;

    assign mask     = size_q[IDX_W-1:0] - ONE;
    assign new_dist = (wr_wdata - rd_q) & mask;
    assign old_dist = (wr_q - rd_q) & mask;
    assign ovf      = wr_we && (new_dist < old_dist);
    assign pending  = (rd_q != wr_q);
    assign size_o   = size_q;
    assign wr_idx   = wr_q;
    assign rd_idx   = rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= '0;
            wr_q   <= '0;
            rd_q   <= '0;
        end else if (size_we) begin
            size_q <= size_wdata;
            wr_q   <= '0;
            rd_q   <= '0;
        end else begin
            if (wr_we && !ovf) wr_q <= wr_wdata & mask;
            if (adv)           rd_q <= (rd_q + ONE) & mask;
        end
    end

    AST_ADV_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (rd_idx != wr_idx)); // R3
    AST_WR_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_we && !size_we) |=> $stable(wr_idx)); // R3
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !size_we) |=> $stable(rd_idx)); // R8
endmodule

// File: rtl/ce_regs.sv
module ce_regs
    import ce_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [7:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic [1:0][IDX_W:0]    ring_size,
    input  logic [1:0][IDX_W-1:0]  ring_wr,
    input  logic [1:0][IDX_W-1:0]  ring_rd,
    input  logic [1:0]             ring_ovf,
    output logic [1:0]             size_we,
    output logic [1:0]             wr_we,
    input  logic                   halted,
    input  logic                   cc_set,
    input  logic [2:0]             eng_err,
    output logic [31:0]            src_base,
    output logic [31:0]            dst_base,
    output logic [CTRL_W-1:0]      ctrl,
    output logic                   halt_req,
    output logic                   err_stop,
    output logic                   irq
);
    logic        ien_q, cc_q;
    logic [9:5]  err_q;
    logic [4:0]  err_set;
    logic        wr_istat, wr_err;

    assign size_we  = {reg_we && reg_addr == OFS_DST_SIZE, reg_we && reg_addr == OFS_SRC_SIZE};
    assign wr_we    = {reg_we && reg_addr == OFS_DST_WR,   reg_we && reg_addr == OFS_SRC_WR};
    assign wr_istat = reg_we && reg_addr == OFS_ISTAT;
    assign wr_err   = reg_we && reg_addr == OFS_ERR;
    assign err_set  = {eng_err, ring_ovf[1], ring_ovf[0]};
    assign err_stop = |err_q[9:7];
    assign irq      = cc_q & ien_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_base <= '0;
            dst_base <= '0;
            ctrl     <= '0;
            halt_req <= 1'b0;
            ien_q    <= 1'b0;
            cc_q     <= 1'b0;
            err_q    <= '0;
        end else begin
            if (reg_we) begin
                unique case (reg_addr)
                    OFS_SRC_BASE: src_base <= reg_wdata;
                    OFS_DST_BASE: dst_base <= reg_wdata;
                    OFS_CTRL:     ctrl     <= reg_wdata[CTRL_W-1:0];
                    OFS_CMD:      halt_req <= reg_wdata[0];
                    OFS_IEN:      ien_q    <= reg_wdata[0];
                    default: ;
                endcase
            end
            cc_q  <= cc_set | (cc_q & ~(wr_istat & reg_wdata[0]));
            err_q <= err_set | (err_q & ~({5{wr_err}} & reg_wdata[9:5]));
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_SRC_BASE: reg_rdata = src_base;
            OFS_SRC_SIZE: reg_rdata = 32'(ring_size[0]);
            OFS_DST_BASE: reg_rdata = dst_base;
            OFS_DST_SIZE: reg_rdata = 32'(ring_size[1]);
            OFS_CTRL:     reg_rdata = 32'(ctrl);
            OFS_CMD:      reg_rdata = {28'h0, halted, 2'b00, halt_req};
            OFS_IEN:      reg_rdata = {31'h0, ien_q};
            OFS_ISTAT:    reg_rdata = {31'h0, cc_q};
            OFS_ERR:      reg_rdata = {22'h0, err_q, 5'h0};
            OFS_SRC_WR:   reg_rdata = 32'(ring_wr[0]);
            OFS_DST_WR:   reg_rdata = 32'(ring_wr[1]);
            OFS_SRC_RD:   reg_rdata = 32'(ring_rd[0]);
            OFS_DST_RD:   reg_rdata = 32'(ring_rd[1]);
            default:      reg_rdata = '0;
        endcase
    end

    AST_CC_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_set && ien_q && !reg_we) |=> irq); // R9
endmodule

// File: rtl/ce_engine.sv
module ce_engine
    import ce_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      src_base,
    input  logic [31:0]      dst_base,
    input  logic [17:0]      ctrl,
    input  logic             halt_req,
    input  logic             err_stop,
    input  logic [IDX_W-1:0] src_rd,
    input  logic [IDX_W-1:0] dst_rd,
    input  logic             src_pending,
    input  logic             dst_pending,
    input  logic [31:0]      mem_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    output logic             src_adv,
    output logic             dst_adv,
    output logic             cc_set,
    output logic [2:0]       eng_err,
    output logic             halted
);
    localparam int PAD_W = 29 - IDX_W;

    ce_state_e st, st_nxt;
    logic [31:0] src_ptr, dst_ptr, sdesc, ddesc;
    logic [15:0] left_q, total_q, len;
    logic        chain_q, swap_q;
    logic [16:0] sum;
    logic        e_daddr, e_slen, e_dmax;

    assign sdesc   = src_base + {{PAD_W{1'b0}}, src_rd, 3'b000};
    assign ddesc   = dst_base + {{PAD_W{1'b0}}, dst_rd, 3'b000};
    assign len     = mem_rdata[15:0];
    assign sum     = {1'b0, total_q} + {1'b0, len};
    assign halted  = (st == ST_HALT);
    assign eng_err = {e_daddr, e_slen, e_dmax};

    always_comb begin
        st_nxt  = st;
        src_adv = 1'b0;
        dst_adv = 1'b0;
        cc_set  = 1'b0;
        e_daddr = 1'b0;
        e_slen  = 1'b0;
        e_dmax  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (halt_req || err_stop)        st_nxt = ST_HALT;
                else if (src_pending && dst_pending) st_nxt = ST_DST_RD;
            end
            ST_DST_RD:  st_nxt = ST_DST_CHK;
            ST_DST_CHK: begin
                if (mem_rdata[1:0] != 2'b00) begin
                    e_daddr = 1'b1;
                    st_nxt  = ST_HALT;
                end else st_nxt = ST_SRC_RD0;
            end
            ST_SRC_RD0: if (src_pending) st_nxt = ST_SRC_RD1;
            ST_SRC_RD1: st_nxt = ST_SRC_CHK;
            ST_SRC_CHK: begin
                if (len == 16'h0 || len[1:0] != 2'b00) begin
                    e_slen = 1'b1;
                    st_nxt = ST_HALT;
                end else if (sum > {1'b0, ctrl[15:0]}) begin
                    e_dmax = 1'b1;
                    st_nxt = ST_HALT;
                end else st_nxt = ST_CP_RD;
            end
            ST_CP_RD: st_nxt = ST_CP_WR;
            ST_CP_WR: begin
                if (left_q == 16'd4) begin
                    src_adv = 1'b1;
                    st_nxt  = chain_q ? ST_SRC_RD0 : ST_WB;
                end else st_nxt = ST_CP_RD;
            end
            ST_WB: begin
                dst_adv = 1'b1;
                cc_set  = 1'b1;
                st_nxt  = ST_IDLE;
            end
            ST_HALT: if (!halt_req && !err_stop) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_ptr <= '0;
            dst_ptr <= '0;
            left_q  <= '0;
            total_q <= '0;
            chain_q <= 1'b0;
            swap_q  <= 1'b0;
        end else begin
            unique case (st)
                ST_DST_CHK: begin
                    dst_ptr <= mem_rdata;
                    total_q <= '0;
                end
                ST_SRC_RD1: src_ptr <= mem_rdata;
                ST_SRC_CHK: begin
                    left_q  <= len;
                    total_q <= sum[15:0];
                    chain_q <= mem_rdata[16];
                    swap_q  <= mem_rdata[17];
                end
                ST_CP_WR: begin
                    src_ptr <= src_ptr + 32'd4;
                    dst_ptr <= dst_ptr + 32'd4;
                    left_q  <= left_q - 16'd4;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st)
            ST_DST_RD: begin
                mem_req  = 1'b1;
                mem_addr = ddesc;
            end
            ST_SRC_RD0: begin
                mem_req  = src_pending;
                mem_addr = sdesc;
            end
            ST_SRC_RD1: begin
                mem_req  = 1'b1;
                mem_addr = sdesc + 32'd4;
            end
            ST_CP_RD: begin
                mem_req  = 1'b1;
                mem_addr = src_ptr;
            end
            ST_CP_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_ptr;
                mem_wdata = (swap_q || ctrl[16]) ? byte_rev(mem_rdata) : mem_rdata;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ddesc + 32'd4;
                mem_wdata = ctrl[17] ? byte_rev({16'h0, total_q}) : {16'h0, total_q};
            end
            default: ;
        endcase
    end

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req); // R8
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (|eng_err) |=> halted); // R10
endmodule

// File: rtl/ce_copy_engine.sv
module ce_copy_engine
    import ce_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        irq
);
    logic [1:0][IDX_W:0]   ring_size;
    logic [1:0][IDX_W-1:0] ring_wr, ring_rd;
    logic [1:0]            ring_pend, ring_ovf, size_we, wr_we, ring_adv;
    logic [31:0]           src_base, dst_base;
    logic [CTRL_W-1:0]     ctrl;
    logic                  halt_req, err_stop, halted, cc_set;
    logic [2:0]            eng_err;

    for (genvar g = 0; g < 2; g++) begin : g_ring
        ce_ring #(.IDX_W(IDX_W)) u_ring (
            .clk        (clk),
            .rst_n      (rst_n),
            .size_we    (size_we[g]),
            .size_wdata (reg_wdata[IDX_W:0]),
            .wr_we      (wr_we[g]),
            .wr_wdata   (reg_wdata[IDX_W-1:0]),
            .adv        (ring_adv[g]),
            .size_o     (ring_size[g]),
            .wr_idx     (ring_wr[g]),
            .rd_idx     (ring_rd[g]),
            .pending    (ring_pend[g]),
            .ovf        (ring_ovf[g])
        );
    end

    ce_regs #(.IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ring_size (ring_size),
        .ring_wr   (ring_wr),
        .ring_rd   (ring_rd),
        .ring_ovf  (ring_ovf),
        .size_we   (size_we),
        .wr_we     (wr_we),
        .halted    (halted),
        .cc_set    (cc_set),
        .eng_err   (eng_err),
        .src_base  (src_base),
        .dst_base  (dst_base),
        .ctrl      (ctrl),
        .halt_req  (halt_req),
        .err_stop  (err_stop),
        .irq       (irq)
    );

    ce_engine #(.IDX_W(IDX_W)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_base    (src_base),
        .dst_base    (dst_base),
        .ctrl        (ctrl[17:0]),
        .halt_req    (halt_req),
        .err_stop    (err_stop),
        .src_rd      (ring_rd[0]),
        .dst_rd      (ring_rd[1]),
        .src_pending (ring_pend[0]),
        .dst_pending (ring_pend[1]),
        .mem_rdata   (mem_rdata),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .src_adv     (ring_adv[0]),
        .dst_adv     (ring_adv[1]),
        .cc_set      (cc_set),
        .eng_err     (eng_err),
        .halted      (halted)
    );
endmodule

// File: tb/ce_copy_engine_bench.sv
module ce_copy_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] SRC_RING = 32'h000;
    localparam logic [31:0] DST_RING = 32'h040;
    localparam logic [31:0] DST_BUF  = 32'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, irq;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem [0:255];

    int n_chk = 0;
    int n_fail = 0;
    int sidx = 0;
    int didx = 0;
    int n_src;
    int lens [3];
    logic [15:0] xflags;
    logic sw_data, sw_wb;
    int tag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ce_copy_engine u_ce_copy_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] pat(input int t, input int j, input int w);
        return 32'hC0DE_0000 | 32'(t << 8) | 32'(j << 4) | 32'(w);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_reg(input string req, input logic [7:0] a, input logic [31:0] m,
                            input logic [31:0] exp);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 3000; i++) begin
            rd(a, v);
            if ((v & m) == exp) break;
        end
        chk(req, v & m, exp);
    endtask

    task automatic post();
        logic [31:0] a;
        tag++;
        for (int k = 128; k < 192; k++) mem[k] = '0;
        for (int j = 0; j < n_src; j++) begin
            a = SRC_RING + 32'(((sidx + j) & 3) * 8);
            mem[a[9:2]]     = 32'h100 + 32'(j * 64);
            mem[a[9:2] + 1] = {xflags | ((j < n_src - 1) ? 16'h1 : 16'h0), 16'(lens[j])};
            for (int w = 0; w < lens[j] / 4; w++) mem[64 + 16 * j + w] = pat(tag, j, w);
        end
        a = DST_RING + 32'(didx * 8);
        mem[a[9:2]]     = DST_BUF;
        mem[a[9:2] + 1] = '0;
        wr(8'h40, 32'((didx + 1) & 3));
        wr(8'h3C, 32'((sidx + n_src) & 3));
    endtask

    task automatic verify(input string req);
        logic [31:0] v, e, a;
        int k, tot;
        k = 0; tot = 0;
        wait_reg({req, " dst read index"}, 8'h48, 32'hF, 32'((didx + 1) & 3));
        for (int j = 0; j < n_src; j++) begin
            for (int w = 0; w < lens[j] / 4; w++) begin
                e = sw_data ? rev(pat(tag, j, w)) : pat(tag, j, w);
                chk({req, " data"}, mem[128 + k], e);
                k++;
            end
            tot += lens[j];
        end
        a = DST_RING + 32'(didx * 8);
        e = sw_wb ? rev(32'(tot)) : 32'(tot);
        chk({req, " R5 writeback"}, mem[a[9:2] + 1], e);
        rd(8'h44, v);
        chk({req, " R3 src read index"}, v, 32'((sidx + n_src) & 3));
        sidx = (sidx + n_src) & 3;
        didx = (didx + 1) & 3;
    endtask

    task automatic clr_irq();
        logic [31:0] v;
        wr(8'h30, 32'h1);
        rd(8'h30, v);
        chk("R9 status cleared", v, 32'h0);
        chk("R9 irq low", 32'(irq), 32'h0);
    endtask

    task automatic single(input int l, input string req);
        n_src = 1; lens[0] = l;
        post();
        verify(req);
        chk("R9 irq after transfer", 32'(irq), 32'h1);
        clr_irq();
    endtask

    initial begin
        logic [31:0] v;
        for (int k = 0; k < 256; k++) mem[k] = '0;
        xflags = '0; sw_data = 1'b0; sw_wb = 1'b0; n_src = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(8'h10, v); chk("R1 ctrl", v, 0);
        rd(8'h18, v); chk("R1 cmd", v, 0);
        rd(8'h30, v); chk("R1 status", v, 0);
        rd(8'h38, v); chk("R1 errors", v, 0);
        rd(8'h44, v); chk("R1 src read index", v, 0);
        rd(8'h48, v); chk("R1 dst read index", v, 0);
        chk("R1 irq", 32'(irq), 0);

        // R2: writable masks
        wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); chk("R2 ctrl mask", v, 32'h0007_FFFF);
        wr(8'h18, 32'h0000_0008); rd(8'h18, v); chk("R2 cmd status read-only", v, 0);

        wr(8'h00, SRC_RING); wr(8'h04, 4);
        wr(8'h08, DST_RING); wr(8'h0C, 4);
        wr(8'h10, 32'h40);   wr(8'h2C, 1);
        rd(8'h04, v); chk("R3 src entries", v, 4);

        // R3 R4 R5 R9: length sweep, wraps the 4-entry rings
        single(4,  "R4 len4");
        single(8,  "R4 len8");
        single(16, "R4 len16");
        single(32, "R4 len32");
        single(12, "R3 wrapped");

        // R6: chaining
        n_src = 2; lens[0] = 8; lens[1] = 12; post(); verify("R6 two"); clr_irq();
        n_src = 3; lens[0] = 4; lens[1] = 4; lens[2] = 8; post(); verify("R6 three"); clr_irq();

        // R7: swapping
        sw_data = 1'b1; xflags = 16'h2; single(8, "R7 flag swap");
        xflags = 16'h0; wr(8'h10, 32'h1_0040); single(8, "R7 ctrl data swap");
        sw_data = 1'b0; sw_wb = 1'b1; wr(8'h10, 32'h2_0040); single(12, "R7 writeback swap");
        sw_wb = 1'b0; wr(8'h10, 32'h40);

        // R9: enable gates irq
        wr(8'h2C, 0);
        n_src = 1; lens[0] = 4; post(); verify("R9 masked");
        rd(8'h30, v); chk("R9 status set while masked", v, 1);
        chk("R9 irq masked", 32'(irq), 0);
        wr(8'h2C, 1); chk("R9 irq after enable", 32'(irq), 1);
        clr_irq();

        // R10: bad source length
        n_src = 1; lens[0] = 6; post();
        wait_reg("R10 error bit", 8'h38, 32'hFFFF_FFFF, 32'h100);
        rd(8'h18, v); chk("R10 stopped", v, 32'h8);
        rd(8'h44, v); chk("R10 src index kept", v, 32'(sidx));
        lens[0] = 8;
        mem[(SRC_RING[9:2] + 8'(sidx * 2)) + 1] = 32'h8;
        for (int w = 0; w < 2; w++) mem[64 + w] = pat(tag, 0, w);
        wr(8'h38, 32'h100);
        verify("R10 recovered"); clr_irq();

        // R11: max length
        wr(8'h10, 32'h8);
        n_src = 1; lens[0] = 16; post();
        wait_reg("R11 error bit", 8'h38, 32'hFFFF_FFFF, 32'h80);
        rd(8'h48, v); chk("R11 dst index kept", v, 32'(didx));
        wr(8'h10, 32'h40); wr(8'h38, 32'h80);
        verify("R11 recovered"); clr_irq();

        // R12: misaligned destination
        n_src = 1; lens[0] = 8; post();
        mem[(DST_RING[9:2] + 8'(didx * 2))] = DST_BUF + 2;
        wait_reg("R12 error bit", 8'h38, 32'hFFFF_FFFF, 32'h200);
        chk("R12 no data written", mem[128], 0);
        mem[(DST_RING[9:2] + 8'(didx * 2))] = DST_BUF;
        wr(8'h38, 32'h200);
        verify("R12 recovered"); clr_irq();

        // R8 R13: halt, overflow
        wr(8'h18, 1);
        wait_reg("R8 stopped status", 8'h18, 32'hFFFF_FFFF, 32'h9);
        n_src = 1; lens[0] = 8; post();
        repeat (40) @(negedge clk);
        rd(8'h44, v); chk("R8 src index frozen", v, 32'(sidx));
        rd(8'h48, v); chk("R8 dst index frozen", v, 32'(didx));
        wr(8'h3C, 32'(sidx));
        rd(8'h38, v); chk("R13 src overflow bit", v, 32'h20);
        rd(8'h3C, v); chk("R13 src write ignored", v, 32'((sidx + 1) & 3));
        wr(8'h40, 32'(didx));
        rd(8'h38, v); chk("R13 dst overflow bit", v, 32'h60);
        rd(8'h40, v); chk("R13 dst write ignored", v, 32'((didx + 1) & 3));
        wr(8'h38, 32'h60);
        rd(8'h38, v); chk("R13 cleared", v, 0);
        wr(8'h18, 0);
        verify("R8 resumed"); clr_irq();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule